// File: doc/BRIEF.md
# Cache Stall Cause Tracker

This block records why the request-accepting side of a cache is stalled. It keeps one bit for each stall cause and drives a single `blocked` line toward the upstream port. That line is high while any cause is present.

Two of the causes come from resource queues: the miss-register queue and the write buffer. Each queue reports allocate and mark-in-service events, along with its full status before and after the event. A queue's bit is set when an allocation leaves that queue full. The bit is cleared when a service event takes the queue from full to not full. The third cause, no free targets, has its own set and clear strobes.

A stall episode begins when the cause mask goes from empty to non-empty. The block counts each episode once, against the cause that opened it. It credits the number of stalled cycles to the cause whose removal empties the mask. Both kinds of counter saturate and are read through a small address/data port. The block also stamps every queue allocation with an increasing order tag.

Top module: `stall_cause_tracker`

## Requirements
- R1: After synchronous active-high reset, `blocked` is 0, every readable counter is 0 and both order tags are 0.
- R2: An allocate event on the miss-register queue (`qAlloc[0]`) or the write buffer (`qAlloc[1]`) sets that queue's cause bit when the queue's `qFullPost` bit is 1. If `qFullPost` is 0, nothing changes. The cause bit indices are 0 for the miss-register queue, 1 for the write buffer and 2 for no free targets.
- R3: A service event (`qSvc[n]`) clears cause bit n only when `qFullPre[n]` is 1 and `qFullPost[n]` is 0. Any other combination leaves the bit unchanged.
- R4: `tgtSet` sets cause bit 2 and `tgtClr` clears it.
- R5: `blocked` is 1 exactly when at least one cause bit is set. It updates on the clock edge that applies the event.
- R6: When the cause mask was empty before a set, the episode counter of the cause being set is incremented. If several causes open an episode in the same cycle, only the lowest-numbered one is counted. A set while the mask is non-empty counts no episode.
- R7: When a clear empties the mask, the number of clock edges since the edge that opened the episode is added to the stall-cycle counter of the cause being cleared. If several causes are cleared in that cycle, the lowest-numbered one receives the credit.
- R8: When set and clear reach the same cause in the same cycle, the clear wins. Setting a bit that is already set has no effect.
- R9: Episode and stall-cycle counters saturate at their all-ones value instead of wrapping.
- R10: `tagMshr` shows the current order number and `tagWbuf` shows that number plus `qAlloc[0]`. After each edge, the order number advances by the number of allocate events in that cycle.
- R11: The read map is combinational. Address 0 to 2 returns the episode counter of cause 0 to 2. Address 4 to 6 returns the stall-cycle counter of cause 0 to 2. Addresses 3 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qAlloc | input | 2 | Allocate event: bit 0 miss-register queue, bit 1 write buffer |
| qSvc | input | 2 | Mark-in-service event for each queue |
| qFullPre | input | 2 | Queue full status before this cycle's event |
| qFullPost | input | 2 | Queue full status after this cycle's event |
| tgtSet | input | 1 | Raise the no-free-targets cause |
| tgtClr | input | 1 | Drop the no-free-targets cause |
| blocked | output | 1 | Upstream stall indication |
| tagMshr | output | ORDER_W | Order tag for a miss-register queue allocation this cycle |
| tagWbuf | output | ORDER_W | Order tag for a write buffer allocation this cycle |
| rdAddr | input | 3 | Counter read address |
| rdData | output | CNT_W | Counter read data |

## Verification
All events are registered, so `blocked` and the counters change on the first edge after the event is driven. The bench drives each event for one cycle starting at a falling edge and reads results at the next falling edge. The order tags and the read port are combinational, so the bench samples them one time step after driving the address or allocate inputs, with no edge between. Expected stall-cycle credits are counted as the number of rising edges from the opening event to the closing event, which follows directly from the way each task spaces its events. The bench builds the block with 8-bit counters so that the saturation points can be reached.

// File: rtl/stall_pkg.sv
package stall_pkg;
  localparam int NUM_CAUSE = 3;
  localparam int CAUSE_W = 2;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_MSHR = 2'd0,
    CAUSE_WBUF = 2'd1,
    CAUSE_TGT  = 2'd2
  } cause_e;

  typedef struct packed {
    logic               epInc;
    logic [CAUSE_W-1:0] epCause;
    logic               capture;
    logic               endValid;
    logic [CAUSE_W-1:0] endCause;
  } strobe_t;

  function automatic logic [CAUSE_W-1:0] lowIdx(input logic [NUM_CAUSE-1:0] v);
    lowIdx = '0;
    for (int i = NUM_CAUSE - 1; i >= 0; i--) begin
      if (v[i]) lowIdx = CAUSE_W'(i);
    end
  endfunction
endpackage

// File: rtl/stall_ctrl.sv
module stall_ctrl
  import stall_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] qAlloc,
  input  logic [1:0] qSvc,
  input  logic [1:0] qFullPre,
  input  logic [1:0] qFullPost,
  input  logic       tgtSet,
  input  logic       tgtClr,
  output logic       blocked,
  output strobe_t    strb
);
  logic [NUM_CAUSE-1:0] maskQ, setVec, clrVec, effSet, nextMask;

  always_comb begin
    setVec   = {tgtSet, qAlloc & qFullPost};
    clrVec   = {tgtClr, qSvc & qFullPre & ~qFullPost};
    effSet   = setVec & ~clrVec;
    nextMask = (maskQ | effSet) & ~clrVec;
    strb.epInc    = (maskQ == '0) && (effSet != '0);
    strb.epCause  = lowIdx(effSet);
    strb.capture  = strb.epInc;
    strb.endValid = (maskQ != '0) && (nextMask == '0);
    strb.endCause = lowIdx(clrVec & maskQ);
  end

  always_ff @(posedge clk) begin
    if (rst) maskQ <= '0;
    else     maskQ <= nextMask;
  end

  assign blocked = |maskQ;

  AST_ALLOC_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (qAlloc[0] && qFullPost[0] && !clrVec[0]) |=> blocked); // R2
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!blocked && setVec == '0) |=> !blocked); // R5
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
    tgtClr |=> !maskQ[CAUSE_TGT]); // R8
endmodule

// File: rtl/stall_sataccum.sv
module stall_sataccum #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         addEn,
  input  logic [W-1:0] addVal,
  output logic [W-1:0] value
);
  logic [W:0] sum;

  assign sum = {1'b0, value} + {1'b0, addVal};

  always_ff @(posedge clk) begin
    if (rst)        value <= '0;
    else if (addEn) value <= sum[W] ? '1 : sum[W-1:0];
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (value == '1) |=> (value == '1)); // R9
endmodule

// File: rtl/stall_dp.sv
module stall_dp
  import stall_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strb,
  input  logic [2:0]       rdAddr,
  output logic [CNT_W-1:0] rdData
);
  logic [CNT_W-1:0] cycleCnt, startQ, elapsed;
  logic [NUM_CAUSE-1:0][CNT_W-1:0] epVal, stallVal;
  logic activeQ;

  assign elapsed = cycleCnt - startQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      cycleCnt <= '0;
      startQ   <= '0;
      activeQ  <= 1'b0;
    end else begin
      cycleCnt <= cycleCnt + 1'b1;
      if (strb.capture) begin
        startQ  <= cycleCnt;
        activeQ <= 1'b1;
      end else if (strb.endValid) begin
        activeQ <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NUM_CAUSE; g++) begin : gCause
    stall_sataccum #(.W(CNT_W)) i_ep (
      .clk(clk), .rst(rst),
      .addEn(strb.epInc && strb.epCause == CAUSE_W'(g)),
      .addVal(CNT_W'(1)),
      .value(epVal[g])
    );
    stall_sataccum #(.W(CNT_W)) i_stall (
      .clk(clk), .rst(rst),
      .addEn(strb.endValid && strb.endCause == CAUSE_W'(g)),
      .addVal(elapsed),
      .value(stallVal[g])
    );
  end

  always_comb begin
    rdData = '0;
    if (rdAddr[1:0] != 2'd3) begin
      rdData = rdAddr[2] ? stallVal[rdAddr[1:0]] : epVal[rdAddr[1:0]];
    end
  end

  AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
    strb.epInc |-> !activeQ); // R6
  AST_END_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    strb.endValid |-> activeQ); // R7
endmodule

// File: rtl/stall_order.sv
module stall_order #(
  parameter int ORDER_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         qAlloc,
  output logic [ORDER_W-1:0] tagMshr,
  output logic [ORDER_W-1:0] tagWbuf
);
  logic [ORDER_W-1:0] orderQ;

  assign tagMshr = orderQ;
  assign tagWbuf = orderQ + ORDER_W'(qAlloc[0]);

  always_ff @(posedge clk) begin
    if (rst) orderQ <= '0;
    else     orderQ <= orderQ + ORDER_W'(qAlloc[0]) + ORDER_W'(qAlloc[1]);
  end

  AST_ORDER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (qAlloc == 2'b00) |=> $stable(orderQ)); // R10
endmodule

// File: rtl/stall_cause_tracker.sv
module stall_cause_tracker
  import stall_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int ORDER_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         qAlloc,
  input  logic [1:0]         qSvc,
  input  logic [1:0]         qFullPre,
  input  logic [1:0]         qFullPost,
  input  logic               tgtSet,
  input  logic               tgtClr,
  output logic               blocked,
  output logic [ORDER_W-1:0] tagMshr,
  output logic [ORDER_W-1:0] tagWbuf,
  input  logic [2:0]         rdAddr,
  output logic [CNT_W-1:0]   rdData
);
  strobe_t strb;

  stall_ctrl i_ctrl (
    .clk(clk), .rst(rst), .qAlloc(qAlloc), .qSvc(qSvc),
    .qFullPre(qFullPre), .qFullPost(qFullPost),
    .tgtSet(tgtSet), .tgtClr(tgtClr), .blocked(blocked), .strb(strb)
  );

  stall_dp #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rst(rst), .strb(strb), .rdAddr(rdAddr), .rdData(rdData)
  );

  stall_order #(.ORDER_W(ORDER_W)) i_order (
    .clk(clk), .rst(rst), .qAlloc(qAlloc), .tagMshr(tagMshr), .tagWbuf(tagWbuf)
  );
endmodule

// File: tb/test_stall_cause_tracker.sv
module test_stall_cause_tracker;
  localparam int CW = 8;
  localparam int OW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] qAlloc = '0, qSvc = '0, qFullPre = '0, qFullPost = '0;
  logic tgtSet = 1'b0, tgtClr = 1'b0;
  logic blocked;
  logic [OW-1:0] tagMshr, tagWbuf;
  logic [2:0] rdAddr = '0;
  logic [CW-1:0] rdData;
  int nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  stall_cause_tracker #(.CNT_W(CW), .ORDER_W(OW)) i_stall_cause_tracker (
    .clk(clk), .rst(rst), .qAlloc(qAlloc), .qSvc(qSvc), .qFullPre(qFullPre),
    .qFullPost(qFullPost), .tgtSet(tgtSet), .tgtClr(tgtClr), .blocked(blocked),
    .tagMshr(tagMshr), .tagWbuf(tagWbuf), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(input int addr, output int val);
    rdAddr = 3'(addr);
    #1;
    val = int'(rdData);
  endtask

  task automatic chkReg(input string req, input int addr, input int exp);
    int v;
    rd(addr, v);
    chk(req, v, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one-cycle event, returns at the following falling edge
  task automatic ev(input logic [1:0] a, input logic [1:0] s, input logic [1:0] pre,
                    input logic [1:0] post, input logic ts, input logic tc);
    qAlloc = a; qSvc = s; qFullPre = pre; qFullPost = post; tgtSet = ts; tgtClr = tc;
    @(negedge clk);
    qAlloc = '0; qSvc = '0; qFullPre = '0; qFullPost = '0; tgtSet = 1'b0; tgtClr = 1'b0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
  endtask

  task automatic tReset();
    doReset();
    chk("R1 blocked", int'(blocked), 0);
    for (int a = 0; a < 8; a++) chkReg("R1/R11 counter", a, 0);
    chk("R1 tagMshr", int'(tagMshr), 0);
    chk("R1 tagWbuf", int'(tagWbuf), 0);
  endtask

  task automatic tAllocMshr();
    doReset();
    ev(2'b01, 2'b00, 2'b00, 2'b00, 0, 0);
    chk("R2 alloc not full", int'(blocked), 0);
    chkReg("R2 no episode", 0, 0);
    ev(2'b01, 2'b00, 2'b00, 2'b01, 0, 0);
    chk("R2 alloc full blocks", int'(blocked), 1);
    chkReg("R6 episode cause0", 0, 1);
    idle(4);
    ev(2'b00, 2'b01, 2'b01, 2'b00, 0, 0);
    chk("R3 svc clears", int'(blocked), 0);
    chkReg("R7 stall cause0", 4, 5);
  endtask

  task automatic tSvcWbuf();
    doReset();
    ev(2'b10, 2'b00, 2'b00, 2'b10, 0, 0);
    chk("R2 wbuf full blocks", int'(blocked), 1);
    ev(2'b00, 2'b10, 2'b10, 2'b10, 0, 0);
    chk("R3 still full keeps", int'(blocked), 1);
    ev(2'b00, 2'b10, 2'b00, 2'b00, 0, 0);
    chk("R3 not full before keeps", int'(blocked), 1);
    ev(2'b00, 2'b10, 2'b10, 2'b00, 0, 0);
    chk("R3 full to not full clears", int'(blocked), 0);
    chkReg("R6 episode cause1", 1, 1);
    chkReg("R7 stall cause1", 5, 3);
  endtask

  task automatic tLastClear();
    doReset();
    ev(2'b00, 2'b00, 2'b00, 2'b00, 1, 0);
    chk("R4 tgtSet blocks", int'(blocked), 1);
    chkReg("R6 episode cause2", 2, 1);
    idle(2);
    ev(2'b01, 2'b00, 2'b00, 2'b01, 0, 0);
    chkReg("R6 no episode while blocked", 0, 0);
    idle(3);
    ev(2'b00, 2'b00, 2'b00, 2'b00, 0, 1);
    chk("R5 one cause left", int'(blocked), 1);
    idle(1);
    ev(2'b00, 2'b01, 2'b01, 2'b00, 0, 0);
    chk("R5 all clear", int'(blocked), 0);
    chkReg("R7 last clearer credited", 4, 9);
    chkReg("R7 earlier clearer not credited", 6, 0);
  endtask

  task automatic tSimultaneous();
    doReset();
    ev(2'b11, 2'b00, 2'b00, 2'b11, 1, 0);
    chkReg("R6 lowest opener", 0, 1);
    chkReg("R6 other opener1", 1, 0);
    chkReg("R6 other opener2", 2, 0);
    ev(2'b00, 2'b11, 2'b11, 2'b00, 0, 1);
    chk("R5 all cleared", int'(blocked), 0);
    chkReg("R7 lowest clearer", 4, 1);
    chkReg("R7 other clearer", 5, 0);
  endtask

  task automatic tPriority();
    doReset();
    ev(2'b00, 2'b00, 2'b00, 2'b00, 1, 1);
    chk("R8 clear wins", int'(blocked), 0);
    chkReg("R8 no episode", 2, 0);
    ev(2'b00, 2'b00, 2'b00, 2'b00, 1, 0);
    ev(2'b00, 2'b00, 2'b00, 2'b00, 1, 0);
    chk("R8 reset still blocked", int'(blocked), 1);
    chkReg("R8 reset no new episode", 2, 1);
    ev(2'b00, 2'b00, 2'b00, 2'b00, 1, 1);
    chk("R8 clear wins when set", int'(blocked), 0);
    chkReg("R7 stall cause2", 6, 2);
  endtask

  task automatic tSaturate();
    doReset();
    for (int i = 0; i < 300; i++) begin
      ev(2'b00, 2'b00, 2'b00, 2'b00, 1, 0);
      ev(2'b00, 2'b00, 2'b00, 2'b00, 0, 1);
    end
    chkReg("R9 episode saturates", 2, 255);
    chkReg("R9 stall saturates", 6, 255);
  endtask

  task automatic tOrder();
    doReset();
    qAlloc = 2'b01; #1;
    chk("R10 tagMshr first", int'(tagMshr), 0);
    chk("R10 tagWbuf first", int'(tagWbuf), 1);
    @(negedge clk);
    qAlloc = 2'b11; #1;
    chk("R10 tagMshr both", int'(tagMshr), 1);
    chk("R10 tagWbuf both", int'(tagWbuf), 2);
    @(negedge clk);
    qAlloc = 2'b10; #1;
    chk("R10 tagWbuf alone", int'(tagWbuf), 3);
    @(negedge clk);
    qAlloc = 2'b00; #1;
    chk("R10 order after", int'(tagMshr), 4);
  endtask

  initial begin
    idle(1);
    tReset();
    tAllocMshr();
    tSvcWbuf();
    tLastClear();
    tSimultaneous();
    tPriority();
    tSaturate();
    tOrder();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #1_000_000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule